// File: doc/BRIEF.md
# Tiled Framebuffer Address Generator

This block produces the address stream for moving a rectangular render-target region between a linear render-target buffer and a tiled on-chip framebuffer. The framebuffer is organised in tiles of 80 dwords by 16 rows, which is 5120 bytes per tile and 320 bytes per tile row. A single start pulse captures the region description: the base tile, the surface pitch in pixels, a 4x multisample flag, a 64-bit-per-pixel flag, the dirty length in tiles and the byte pitch of one linear render-target row. The block then walks the region and emits one address pair per step. Each step covers four dwords (16 bytes).

For every step the block outputs a framebuffer byte address and the matching linear render-target byte address, under a valid/ready handshake. A one-cycle done pulse marks the end of the walk. The data mover that consumes the pairs handles the transfer itself and any format conversion.

Top module: `tfb_addr_gen`

## Requirements
- R1: After reset `addr_valid`, `done` and `busy` are all low.
- R2: The effective pitch in tiles is ceil(P / 80), doubled when `wide64` is 1. P is `pitch_px` when `msaa4x` is 0, or twice `pitch_px` when `msaa4x` is 1. Each tile row of the walk visits exactly that many tiles.
- R3: With `wide64`=0 a step (tile column tx, tile row ty, in-tile row r 0..15, group g 0..19) gives fb_addr = (base + ty*pitch + tx)*5120 + r*320 + g*16.
- R4: With `wide64`=1 groups g run 0..39 and r runs 0..7. Groups 0..19 address in-tile row 2r at dword 4g. Groups 20..39 address in-tile row 2r+1 at dword 4(g-20).
- R5: rt_addr = (ty*H + r)*rt_pitch + (tx*W + g)*16. W=20 and H=16 when `wide64`=0. W=40 and H=8 when `wide64`=1.
- R6: The number of tile rows walked is floor(`dirty_tiles` / effective pitch). If that is zero, or the pitch is zero, no address is issued and only `done` is raised.
- R7: Steps are ordered with the group index fastest, then in-tile row, then tile column, then tile row.
- R8: While `addr_valid` is high and `addr_ready` is low, `addr_valid`, `fb_addr` and `rt_addr` keep their values into the next cycle.
- R9: `done` is high for exactly one cycle. That cycle directly follows the clock edge that accepts the last address, and `addr_valid` is low during it.
- R10: A `start` pulse while `busy` is high has no effect: the running address stream continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Captures the region description when idle |
| base_tile | input | BASE_W | First tile index of the region |
| pitch_px | input | PITCH_W | Surface pitch in pixels |
| msaa4x | input | 1 | 4x multisampling, which doubles the pixel pitch |
| wide64 | input | 1 | 64-bit-per-pixel surface |
| dirty_tiles | input | DLEN_W | Dirty length in tiles |
| rt_pitch | input | RTP_W | Byte pitch of one linear render-target row |
| addr_ready | input | 1 | Consumer accepts the current address pair |
| addr_valid | output | 1 | Address pair present |
| fb_addr | output | FB_W | Framebuffer byte address |
| rt_addr | output | RT_W | Linear render-target byte address |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle end-of-walk pulse |

## Verification
The assertions check four things on every cycle: address hold under back-pressure, the shape of the done pulse, that the captured configuration stays frozen for the whole operation, and the divider's quotient bounds. Only the bench's scenarios can show that the address formulas, the 64-bit row split, the pitch rounding with multisampling and the walk order are right. To do that, the bench compares every accepted pair against a sequence computed independently from the region description. Zero-row regions, pitches just above a tile boundary and a start pulse injected mid-walk are exercised as directed cases.

// File: rtl/tfb_pkg.sv
package tfb_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PREP,
      ST_DIV,
      ST_RUN,
      ST_DONE
   } tfb_state_e;
endpackage

// File: rtl/tfb_pitch_calc.sv
module tfb_pitch_calc #(
   parameter int PITCH_W = 13,
   parameter int PT_W    = PITCH_W + 1,
   parameter int TILE_DW = 80
) (
   input  logic [PITCH_W-1:0] pitch_px,
   input  logic               msaa4x,
   input  logic               wide64,
   output logic [PT_W-1:0]    eff_pitch
);
   localparam int SS_W = PITCH_W + 1;

   logic [SS_W-1:0] ss_px;
   logic [SS_W-1:0] rounded;
   logic [SS_W-1:0] tiles;

   always_comb begin
      ss_px   = msaa4x ? {pitch_px, 1'b0} : {1'b0, pitch_px};
      rounded = ss_px + SS_W'(TILE_DW - 1);
   end

   generate
      if ((TILE_DW & (TILE_DW - 1)) == 0) begin : g_shift
         assign tiles = rounded >> $clog2(TILE_DW);
      end else begin : g_const_div
         assign tiles = rounded / SS_W'(TILE_DW);
      end
   endgenerate

   assign eff_pitch = wide64 ? PT_W'({tiles, 1'b0}) : PT_W'(tiles);
endmodule

// File: rtl/tfb_row_divider.sv
module tfb_row_divider #(
   parameter int NUM_W = 12,
   parameter int DEN_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [NUM_W-1:0] num,
   input  logic [DEN_W-1:0] den,
   output logic             fin,
   output logic [NUM_W-1:0] quot
);
   localparam int CNT_W = $clog2(NUM_W + 1);

   logic [DEN_W:0]   rem;
   logic [DEN_W:0]   trial;
   logic [NUM_W-1:0] num_q;
   logic [DEN_W-1:0] den_q;
   logic [CNT_W-1:0] cnt;
   logic             active;

   assign trial = {rem[DEN_W-1:0], quot[NUM_W-1]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem    <= '0;
         quot   <= '0;
         num_q  <= '0;
         den_q  <= '0;
         cnt    <= '0;
         active <= 1'b0;
         fin    <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (go) begin
            rem    <= '0;
            quot   <= num;
            num_q  <= num;
            den_q  <= den;
            cnt    <= CNT_W'(NUM_W);
            active <= 1'b1;
         end else if (active) begin
            if (trial >= {1'b0, den_q}) begin
               rem  <= trial - {1'b0, den_q};
               quot <= {quot[NUM_W-2:0], 1'b1};
            end else begin
               rem  <= trial;
               quot <= {quot[NUM_W-2:0], 1'b0};
            end
            cnt <= cnt - CNT_W'(1);
            if (cnt == CNT_W'(1)) begin
               active <= 1'b0;
               fin    <= 1'b1;
            end
         end
      end
   end

   // R6: the quotient is the floor of num/den
   assert_quotient_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fin && den_q != '0) |->
         ((NUM_W+DEN_W)'(quot) * (NUM_W+DEN_W)'(den_q) <= (NUM_W+DEN_W)'(num_q)) &&
         ((NUM_W+DEN_W)'(num_q) - (NUM_W+DEN_W)'(quot) * (NUM_W+DEN_W)'(den_q)
            < (NUM_W+DEN_W)'(den_q)));
endmodule

// File: rtl/tfb_tile_walker.sv
module tfb_tile_walker #(
   parameter int BASE_W    = 12,
   parameter int DLEN_W    = 12,
   parameter int PT_W      = 14,
   parameter int RTP_W     = 16,
   parameter int FB_W      = 24,
   parameter int RT_W      = 28,
   parameter int TILE_DW   = 80,
   parameter int TILE_ROWS = 16,
   parameter int VEC_DW    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              adv,
   input  logic              run,
   input  logic              wide,
   input  logic [PT_W-1:0]   eff_pitch,
   input  logic [DLEN_W-1:0] rows,
   input  logic [BASE_W-1:0] base,
   input  logic [RTP_W-1:0]  rtp,
   output logic [FB_W-1:0]   fb_addr,
   output logic [RT_W-1:0]   rt_addr,
   output logic              last
);
   localparam int GRP_N      = TILE_DW / VEC_DW;
   localparam int GRP_WIDE   = 2 * GRP_N;
   localparam int RH_N       = TILE_ROWS;
   localparam int RH_WIDE    = TILE_ROWS / 2;
   localparam int GXW        = $clog2(GRP_WIDE);
   localparam int GYW        = $clog2(TILE_ROWS);
   localparam int ROW_BYTES  = TILE_DW * 4;
   localparam int TILE_BYTES = ROW_BYTES * TILE_ROWS;
   localparam int VEC_BYTES  = VEC_DW * 4;

   logic [GXW-1:0]    gx;
   logic [GYW-1:0]    gy;
   logic [PT_W-1:0]   tx;
   logic [DLEN_W-1:0] ty;
   logic [GXW-1:0]    gx_max;
   logic [GYW-1:0]    gy_max;
   logic              gx_end, gy_end, tx_end, ty_end;
   logic [GYW-1:0]    row_sel;
   logic [GXW-1:0]    grp_sel;
   logic [FB_W-1:0]   fb_off;
   logic [FB_W-1:0]   tile_idx;
   logic [RT_W-1:0]   rt_x, rt_y;

   always_comb begin
      gx_max = wide ? GXW'(GRP_WIDE - 1) : GXW'(GRP_N - 1);
      gy_max = wide ? GYW'(RH_WIDE - 1) : GYW'(RH_N - 1);
      gx_end = (gx == gx_max);
      gy_end = (gy == gy_max);
      tx_end = (tx == eff_pitch - PT_W'(1));
      ty_end = (ty == rows - DLEN_W'(1));
      last   = gx_end && gy_end && tx_end && ty_end;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || load) begin
         gx <= '0;
         gy <= '0;
         tx <= '0;
         ty <= '0;
      end else if (adv) begin
         if (!gx_end) begin
            gx <= gx + GXW'(1);
         end else begin
            gx <= '0;
            if (!gy_end) begin
               gy <= gy + GYW'(1);
            end else begin
               gy <= '0;
               if (!tx_end) begin
                  tx <= tx + PT_W'(1);
               end else begin
                  tx <= '0;
                  ty <= ty + DLEN_W'(1);
               end
            end
         end
      end
   end

   // split of a wide render-target row across two tile rows
   always_comb begin
      if (wide && gx >= GXW'(GRP_N)) begin
         row_sel = {gy[GYW-2:0], 1'b1};
         grp_sel = gx - GXW'(GRP_N);
      end else if (wide) begin
         row_sel = {gy[GYW-2:0], 1'b0};
         grp_sel = gx;
      end else begin
         row_sel = gy;
         grp_sel = gx;
      end
   end

   always_comb begin
      fb_off   = FB_W'(row_sel) * FB_W'(ROW_BYTES) + FB_W'(grp_sel) * FB_W'(VEC_BYTES);
      tile_idx = FB_W'(base) + FB_W'(ty) * FB_W'(eff_pitch) + FB_W'(tx);
      fb_addr  = tile_idx * FB_W'(TILE_BYTES) + fb_off;
      rt_y     = RT_W'(ty) * (wide ? RT_W'(RH_WIDE) : RT_W'(RH_N)) + RT_W'(gy);
      rt_x     = RT_W'(tx) * (wide ? RT_W'(GRP_WIDE) : RT_W'(GRP_N)) + RT_W'(gx);
      rt_addr  = rt_y * RT_W'(rtp) + rt_x * RT_W'(VEC_BYTES);
   end

   // R3: the in-tile offset never leaves the tile
   assert_in_tile_R3: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (fb_off < FB_W'(TILE_BYTES)));

   // R7: the tile row counter never passes the row count during a walk
   assert_row_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (ty < rows));
endmodule

// File: rtl/tfb_addr_gen.sv
module tfb_addr_gen
   import tfb_pkg::*;
#(
   parameter int BASE_W    = 12,
   parameter int PITCH_W   = 13,
   parameter int DLEN_W    = 12,
   parameter int RTP_W     = 16,
   parameter int FB_W      = 24,
   parameter int RT_W      = 28,
   parameter int TILE_DW   = 80,
   parameter int TILE_ROWS = 16,
   parameter int VEC_DW    = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [BASE_W-1:0]  base_tile,
   input  logic [PITCH_W-1:0] pitch_px,
   input  logic               msaa4x,
   input  logic               wide64,
   input  logic [DLEN_W-1:0]  dirty_tiles,
   input  logic [RTP_W-1:0]   rt_pitch,
   input  logic               addr_ready,
   output logic               addr_valid,
   output logic [FB_W-1:0]    fb_addr,
   output logic [RT_W-1:0]    rt_addr,
   output logic               busy,
   output logic               done
);
   localparam int PT_W = PITCH_W + 1;

   generate
      if (TILE_DW % VEC_DW != 0) begin : g_bad_vec
         $error("TILE_DW must be a multiple of VEC_DW");
      end
      if (TILE_ROWS < 2 || (TILE_ROWS % 2) != 0) begin : g_bad_rows
         $error("TILE_ROWS must be even and at least 2");
      end
      if (DLEN_W < 2) begin : g_bad_dlen
         $error("DLEN_W must be at least 2");
      end
   endgenerate

   tfb_state_e         state;
   logic [BASE_W-1:0]  base_q;
   logic [PITCH_W-1:0] pitch_q;
   logic               msaa_q, wide_q;
   logic [DLEN_W-1:0]  dirty_q;
   logic [RTP_W-1:0]   rtp_q;
   logic [DLEN_W-1:0]  rows_q;
   logic [PT_W-1:0]    eff_pitch;
   logic               div_fin;
   logic [DLEN_W-1:0]  div_quot;
   logic               walk_last;
   logic               run;

   assign run        = (state == ST_RUN);
   assign addr_valid = run;
   assign busy       = (state != ST_IDLE);
   assign done       = (state == ST_DONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         base_q  <= '0;
         pitch_q <= '0;
         msaa_q  <= 1'b0;
         wide_q  <= 1'b0;
         dirty_q <= '0;
         rtp_q   <= '0;
         rows_q  <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (start) begin
               base_q  <= base_tile;
               pitch_q <= pitch_px;
               msaa_q  <= msaa4x;
               wide_q  <= wide64;
               dirty_q <= dirty_tiles;
               rtp_q   <= rt_pitch;
               state   <= ST_PREP;
            end
            ST_PREP: state <= ST_DIV;
            ST_DIV: if (div_fin) begin
               rows_q <= div_quot;
               if (eff_pitch == '0 || div_quot == '0) state <= ST_DONE;
               else state <= ST_RUN;
            end
            ST_RUN: if (addr_ready && walk_last) state <= ST_DONE;
            ST_DONE: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   tfb_pitch_calc #(
      .PITCH_W (PITCH_W),
      .PT_W    (PT_W),
      .TILE_DW (TILE_DW)
   ) u_pitch (
      .pitch_px  (pitch_q),
      .msaa4x    (msaa_q),
      .wide64    (wide_q),
      .eff_pitch (eff_pitch)
   );

   tfb_row_divider #(
      .NUM_W (DLEN_W),
      .DEN_W (PT_W)
   ) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (state == ST_PREP),
      .num   (dirty_q),
      .den   (eff_pitch),
      .fin   (div_fin),
      .quot  (div_quot)
   );

   tfb_tile_walker #(
      .BASE_W    (BASE_W),
      .DLEN_W    (DLEN_W),
      .PT_W      (PT_W),
      .RTP_W     (RTP_W),
      .FB_W      (FB_W),
      .RT_W      (RT_W),
      .TILE_DW   (TILE_DW),
      .TILE_ROWS (TILE_ROWS),
      .VEC_DW    (VEC_DW)
   ) u_walk (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (state == ST_PREP),
      .adv       (run && addr_ready),
      .run       (run),
      .wide      (wide_q),
      .eff_pitch (eff_pitch),
      .rows      (rows_q),
      .base      (base_q),
      .rtp       (rtp_q),
      .fb_addr   (fb_addr),
      .rt_addr   (rt_addr),
      .last      (walk_last)
   );

   // R8: back-pressure holds the offered pair
   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_valid && !addr_ready) |=>
         (addr_valid && $stable(fb_addr) && $stable(rt_addr)));

   // R9: done is a single-cycle pulse
   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9: done never overlaps an offered address
   assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && addr_valid));

   // R10: captured configuration stays frozen while busy
   assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |->
         ($stable(base_q) && $stable(pitch_q) && $stable(wide_q) &&
          $stable(msaa_q) && $stable(rtp_q) && $stable(dirty_q)));

   // R1: busy is low only in idle, and idle offers nothing
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!addr_valid && !done));
endmodule

// File: tb/tfb_addr_gen_test.sv
module tfb_addr_gen_test;
   localparam int BASE_W  = 12;
   localparam int PITCH_W = 13;
   localparam int DLEN_W  = 12;
   localparam int RTP_W   = 16;
   localparam int FB_W    = 24;
   localparam int RT_W    = 28;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               start = 1'b0;
   logic [BASE_W-1:0]  base_tile = '0;
   logic [PITCH_W-1:0] pitch_px = '0;
   logic               msaa4x = 1'b0;
   logic               wide64 = 1'b0;
   logic [DLEN_W-1:0]  dirty_tiles = '0;
   logic [RTP_W-1:0]   rt_pitch = '0;
   logic               addr_ready = 1'b0;
   logic               addr_valid;
   logic [FB_W-1:0]    fb_addr;
   logic [RT_W-1:0]    rt_addr;
   logic               busy;
   logic               done;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   longint exp_fb[$];
   longint exp_rt[$];

   always #4 clk = ~clk;

   tfb_addr_gen uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .base_tile   (base_tile),
      .pitch_px    (pitch_px),
      .msaa4x      (msaa4x),
      .wide64      (wide64),
      .dirty_tiles (dirty_tiles),
      .rt_pitch    (rt_pitch),
      .addr_ready  (addr_ready),
      .addr_valid  (addr_valid),
      .fb_addr     (fb_addr),
      .rt_addr     (rt_addr),
      .busy        (busy),
      .done        (done)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic longint eff_pitch_of(input int px, input int ms, input int wd);
      longint ss = ms ? 2 * px : px;
      longint t = (ss + 79) / 80;
      return wd ? 2 * t : t;
   endfunction

   // R2 R3 R4 R5 R6 R7: expected stream built from the requirement formulas
   task automatic build_expected(input int base, input int px, input int ms, input int wd,
                                 input int dl, input int rtp);
      longint eff = eff_pitch_of(px, ms, wd);
      longint rows = (eff == 0) ? 0 : dl / eff;
      int gw = wd ? 40 : 20;
      int gh = wd ? 8 : 16;
      exp_fb.delete();
      exp_rt.delete();
      for (longint ty = 0; ty < rows; ty++)
         for (longint tx = 0; tx < eff; tx++)
            for (int gy = 0; gy < gh; gy++)
               for (int gx = 0; gx < gw; gx++) begin
                  longint row = wd ? (2 * gy + (gx >= 20 ? 1 : 0)) : gy;
                  longint dw  = wd ? 4 * (gx % 20) : 4 * gx;
                  longint fb  = (base + ty * eff + tx) * 5120 + row * 320 + dw * 4;
                  longint rt  = (ty * gh + gy) * rtp + (tx * gw + gx) * 16;
                  exp_fb.push_back(fb & ((64'd1 << FB_W) - 1));
                  exp_rt.push_back(rt & ((64'd1 << RT_W) - 1));
               end
   endtask

   task automatic run_op(input int base, input int px, input int ms, input int wd,
                         input int dl, input int rtp, input int ready_pct, input bit poke);
      int cyc = 0;
      bit last_seen = 1'b0;
      bit hold = 1'b0;
      bit saw_valid = 1'b0;
      longint hold_fb = 0, hold_rt = 0;
      int total;
      build_expected(base, px, ms, wd, dl, rtp);
      total = exp_fb.size();
      @(negedge clk);
      base_tile = BASE_W'(base); pitch_px = PITCH_W'(px); msaa4x = ms[0]; wide64 = wd[0];
      dirty_tiles = DLEN_W'(dl); rt_pitch = RTP_W'(rtp); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      forever begin
         @(negedge clk);
         cyc++;
         if (cyc > 30000) begin
            check(1'b0, "R9 op timeout", cyc, 30000);
            break;
         end
         if (last_seen) begin
            check(done && !addr_valid, "R9 done after last accept", done, 1);
            @(negedge clk);
            check(!done, "R9 done single cycle", done, 0);
            break;
         end
         if (done) begin
            check(total == 0 && !saw_valid, "R6 zero-row op emits nothing", exp_fb.size(), 0);
            @(negedge clk);
            check(!done && !busy, "R9 done single cycle", done, 0);
            break;
         end
         if (poke && cyc == 30) begin
            // R10: a start with other values while busy
            start = 1'b1; base_tile = BASE_W'(base + 7); wide64 = ~wide64;
            pitch_px = PITCH_W'(px + 160); dirty_tiles = DLEN_W'(dl + 3);
         end else if (poke && cyc == 31) begin
            start = 1'b0;
         end
         if (hold)
            check(addr_valid && fb_addr == FB_W'(hold_fb) && rt_addr == RT_W'(hold_rt),
                  "R8 hold under back-pressure", longint'(fb_addr), hold_fb);
         addr_ready = (int'($urandom % 100) < ready_pct);
         if (addr_valid) saw_valid = 1'b1;
         if (addr_valid && addr_ready) begin
            if (exp_fb.size() == 0) begin
               check(1'b0, "R6 extra address beyond row count", longint'(fb_addr), -1);
            end else begin
               longint efb = exp_fb.pop_front();
               longint ert = exp_rt.pop_front();
               check(longint'(fb_addr) == efb, wd ? "R4 R7 fb_addr" : "R3 R7 fb_addr",
                     longint'(fb_addr), efb);
               check(longint'(rt_addr) == ert, "R5 R2 rt_addr", longint'(rt_addr), ert);
               if (exp_fb.size() == 0) last_seen = 1'b1;
            end
         end
         hold = addr_valid && !addr_ready;
         hold_fb = longint'(fb_addr);
         hold_rt = longint'(rt_addr);
      end
      addr_ready = 1'b0;
      check(exp_fb.size() == 0, "R6 R2 all expected addresses issued", exp_fb.size(), 0);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      check(!addr_valid && !done && !busy, "R1 reset outputs", {addr_valid, done, busy}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!addr_valid && !done && !busy, "R1 idle after reset", {addr_valid, done, busy}, 0);
      // directed corner cases
      run_op(0,    80,  0, 0, 1, 320,  100, 0);   // R3 single tile, no back-pressure
      run_op(5,    81,  0, 0, 4, 640,  60,  0);   // R2 pitch just over one tile
      run_op(17,   50,  1, 0, 2, 512,  70,  0);   // R2 msaa doubling to two tiles
      run_op(3,    80,  0, 1, 2, 1024, 50,  0);   // R4 wide split, doubled pitch
      run_op(9,    160, 0, 0, 1, 256,  80,  0);   // R6 dirty shorter than pitch
      run_op(9,    0,   0, 0, 3, 256,  80,  0);   // R6 zero pitch
      run_op(100,  80,  1, 1, 9, 2048, 40,  1);   // R10 start while busy
      // constrained random mix
      for (int i = 0; i < 10; i++) begin
         int px = 1 + int'($urandom % 240);
         int ms = int'($urandom % 2);
         int wd = int'($urandom % 2);
         int ep = int'(eff_pitch_of(px, ms, wd));
         int dl = int'($urandom % (3 * ep + 2));
         int bs = int'($urandom % 2000);
         int rp = 16 * (1 + int'($urandom % 300));
         run_op(bs, px, ms, wd, dl, rp, 30 + int'($urandom % 71), i % 3 == 0);
      end
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 190000, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule